// File: doc/BRIEF.md
# Exact-Length Run Detector

This block watches one serial data bit, sampled once per clock, and raises a one-cycle pulse in the clock cycle where a run of 1s ends, provided that run was exactly three bits long. Runs of one or two 1s produce no pulse. Runs of four or more 1s produce no pulse either: they are rejected, not counted as "at least three".

It is a Mealy machine. The pulse is formed combinationally from the registered state and the bit currently on the input, so it appears in the same cycle as the terminating 0, before the clock edge that consumes that 0. The machine has five states, held in a binary-coded register:

- `ST_IDLE`: no current run, because the last bit was 0.
- `ST_ONE`: one 1 seen.
- `ST_TWO`: two 1s seen.
- `ST_THREE`: three 1s seen.
- `ST_OVER`: more than three 1s seen.

Its transitions are:

- `adv`: a 1 moves the machine from idle to one, one to two, and two to three.
- `spill`: a 1 in three moves it to over.
- `hold`: a 1 in over keeps it in over.
- `clear`: a 0 in any state returns it to idle.
- `recover`: any unused state code goes to idle.

A synchronous reset forces idle and masks the pulse.

Top module: `runlen_exact3_det`

## Requirements
- R1: While `rst_i` is 1, `hit_o` is 0. At the next rising edge the machine enters the idle state, so a bit pattern that follows reset is judged only on bits presented after reset is released.
- R2: When exactly three consecutive 1s have been clocked in and `bit_i` is 0 in the current cycle, `hit_o` is 1 in that same cycle, before the clock edge.
- R3: A run of one or two 1s that ends with a 0 gives `hit_o` = 0 in the terminating cycle.
- R4: A run of four or more 1s gives no pulse, neither during the run nor in the cycle of the terminating 0.
- R5: `hit_o` is 0 in every cycle in which `bit_i` is 1.
- R6: A 0 from any state clears the run count. After any history, the sequence 0,1,1,1,0 pulses on its final 0, so back-to-back three-runs split by a single 0 each pulse.
- R7: `hit_o` is never 1 in two consecutive cycles.
- R8: If reset is asserted in the same cycle as the 0 that ends a run of exactly three, the pulse is suppressed. Reset takes priority over detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial data bit, sampled each rising edge |
| hit_o | output | 1 | Combinational pulse, 1 when a run of exactly three 1s ends in this cycle |

## Verification
Two functions can fall in the same cycle: the run-ending detection, and the synchronous reset that clears the state. The bench builds runs of exactly three 1s and raises `rst_i` together with the terminating 0, and it also scatters resets at random points among random run lengths. In those cycles it expects `hit_o` to be 0 and the following sequence to be judged from idle. The expected values come from a bench model that counts run length, saturates it at four, and applies reset first.

// File: rtl/runlen_pkg.sv
package runlen_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_ONE   = 3'd1,
        ST_TWO   = 3'd2,
        ST_THREE = 3'd3,
        ST_OVER  = 3'd4
    } run_state_e;
endpackage

// File: rtl/runlen_next.sv
module runlen_next
    import runlen_pkg::*;
(
    input  run_state_e cur_i,
    input  logic       bit_i,
    output run_state_e nxt_o
);
    always_comb begin
        nxt_o = ST_IDLE;
        if (bit_i) begin
            unique case (cur_i)
                ST_IDLE:  nxt_o = ST_ONE;    // adv
                ST_ONE:   nxt_o = ST_TWO;    // adv
                ST_TWO:   nxt_o = ST_THREE;  // adv
                ST_THREE: nxt_o = ST_OVER;   // spill
                ST_OVER:  nxt_o = ST_OVER;   // hold
                default:  nxt_o = ST_IDLE;   // recover
            endcase
        end
        // bit_i == 0: clear to ST_IDLE from every state
    end
endmodule

// File: rtl/runlen_out.sv
module runlen_out
    import runlen_pkg::*;
(
    input  run_state_e cur_i,
    input  logic       bit_i,
    input  logic       rst_i,
    output logic       hit_o
);
    always_comb begin
        hit_o = 1'b0;
        unique case (cur_i)
            ST_THREE: hit_o = ~bit_i & ~rst_i;
            default:  hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/runlen_exact3_det.sv
module runlen_exact3_det
    import runlen_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    output logic hit_o
);
    localparam int HIST_MAX = 7;
    localparam int HIST_W   = $clog2(HIST_MAX + 1);

    run_state_e state_q;
    run_state_e state_d;

    runlen_next u_next (
        .cur_i (state_q),
        .bit_i (bit_i),
        .nxt_o (state_d)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    runlen_out u_out (
        .cur_i (state_q),
        .bit_i (bit_i),
        .rst_i (rst_i),
        .hit_o (hit_o)
    );

    // Checking aids: the number of clean cycles since reset, and a reset flag.
    logic [HIST_W-1:0] clean_q;
    logic              was_rst_q;

    always_ff @(posedge clk_i) begin
        was_rst_q <= rst_i;
        if (rst_i)                            clean_q <= '0;
        else if (clean_q != HIST_W'(HIST_MAX)) clean_q <= clean_q + 1'b1;
    end

    // R1
    always @(posedge clk_i) begin
        if (was_rst_q) begin
            reset_idle_chk: assert (state_q == ST_IDLE)
                else $error("state not idle after reset");
        end
    end

    // R1
    always_comb begin
        if (rst_i === 1'b1) begin
            reset_mask_chk: assert (hit_o == 1'b0);
        end
    end

    // R5
    no_hit_on_one_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_i |-> !hit_o);

    // R7
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |=> !hit_o);

    // R2
    exact_three_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (clean_q >= HIST_W'(4) && !bit_i && $past(bit_i) && $past(bit_i, 2)
         && $past(bit_i, 3) && !$past(bit_i, 4)) |-> hit_o);

    // R4
    too_long_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (clean_q >= HIST_W'(4) && $past(bit_i) && $past(bit_i, 2)
         && $past(bit_i, 3) && $past(bit_i, 4)) |-> !hit_o);
endmodule

// File: tb/runlen_exact3_det_test.sv
module runlen_exact3_det_test;
    logic clk_i = 1'b0;
    logic rst_i = 1'b1;
    logic bit_i = 1'b0;
    logic hit_o;

    int total = 0;
    int bad   = 0;
    int run_len = 0;   // bench model: saturating run count
    bit done = 1'b0;

    runlen_exact3_det uut (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .bit_i (bit_i),
        .hit_o (hit_o)
    );

    always #5 clk_i = ~clk_i;

    function automatic logic exp_hit(input int len, input logic b, input logic r);
        return (!r && !b && len == 3);
    endfunction

    function automatic int next_len(input int len, input logic b, input logic r);
        if (r)      return 0;
        else if (b) return (len >= 4) ? 4 : len + 1;
        else        return 0;
    endfunction

    function automatic string req_of(input int len, input logic b, input logic r);
        if (r)         return "R1/R8";
        if (b)         return "R5";
        if (len == 3)  return "R2";
        if (len >= 4)  return "R4";
        if (len > 0)   return "R3";
        return "R6";
    endfunction

    task automatic step(input logic b, input logic r, input string tag);
        logic e;
        @(negedge clk_i);
        bit_i = b;
        rst_i = r;
        #1;
        e = exp_hit(run_len, b, r);
        total++;
        if (hit_o !== e) begin
            bad++;
            $display("FAIL %s (%s): hit_o=%b expected=%b len=%0d bit=%b rst=%b",
                     req_of(run_len, b, r), tag, hit_o, e, run_len, b, r);
        end
        @(posedge clk_i);
        run_len = next_len(run_len, b, r);
    endtask

    task automatic run_of(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, tag);
        step(1'b0, 1'b0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: expired, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state, with 1s presented during reset
        step(1'b1, 1'b1, "R1 reset ones");
        step(1'b1, 1'b1, "R1 reset ones");
        step(1'b0, 1'b1, "R1 reset");
        // R1: bits during reset do not count toward a run
        step(1'b1, 1'b1, "R1 reset ones");
        run_of(2, "R1 post-reset two");
        // R3
        run_of(1, "R3 single");
        run_of(2, "R3 double");
        // R2
        run_of(3, "R2 exact");
        // R4
        run_of(4, "R4 four");
        run_of(7, "R4 seven");
        // R6: back-to-back exact runs split by one 0
        run_of(3, "R6 b2b a");
        run_of(3, "R6 b2b b");
        run_of(5, "R6 after over");
        run_of(3, "R6 after over exact");
        // R8: reset coincides with terminating 0
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R8 setup");
        step(1'b0, 1'b1, "R8 collide");
        run_of(3, "R8 after");
        // R7 and mixed: random run lengths with sporadic resets
        for (int k = 0; k < 3000; k++) begin
            int n = $urandom_range(0, 6);
            for (int i = 0; i < n; i++) begin
                logic r = ($urandom_range(0, 63) == 0);
                step(1'b1, r, "R7 random run");
            end
            step(1'b0, ($urandom_range(0, 31) == 0), "R7 random end");
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule